// File: doc/BRIEF.md
# Stepped Digital Stereo Volume with Fast Mute

This block scales a stereo stream of signed samples by a gain taken from a 16-bit control word. The high byte selects a whole-decibel step, bits [7:5] add an eighth-decibel fine offset, and bits [4:0] select how clipping is handled. Gain changes are never applied at once. The working gain level moves one eighth-decibel step toward its target for every accepted sample, so no sudden jump reaches the output.

One high-byte code is reserved for fast mute. It drives the level down several steps per sample, so the output reaches exact silence within 256 samples from any setting. The block stays silent until software writes an ordinary volume code again.

The gain law treats 6 dB as an exact doubling. A linear mantissa for each eighth-decibel step inside one 6 dB octave is computed at elaboration. It is combined with a binary shift for the octave, and the product is rounded and saturated to the sample width.

Top module: `vol_stepper`

## Requirements
- R1: For high-byte code c in 01h..7Fh with fine field f = ctrlWord[7:5], the gain in dB is (c - 73h) + f/8. The linear gain is 2^(dB/6), so code 73h with f = 0 is unity.
- R2: Code 7Fh gives +12 dB and code 01h gives -114 dB. Codes 80h..FEh act exactly like 7Fh.
- R3: High-byte code 00h is mute, and the whole control word resets to 0000h. At the mute level both outputs are exactly zero.
- R4: The fine field raises the gain in 0.125 dB steps, up to +0.875 dB above the whole-decibel step.
- R5: When the clipping field ctrlWord[4:0] is 0 ("limit gain"), the effective target gain is capped at 0 dB, so the output magnitude never exceeds the input. With any other value the full gain is applied and only saturation limits the output.
- R6: Each product is rounded to the nearest integer and saturated to the signed output range (+32767 / -32768 at 16 bits). It never wraps.
- R7: On each accepted sample the level moves one 0.125 dB step toward the target. The sample is scaled by the level held before that step.
- R8: High-byte code FFh starts fast mute. The level falls by FAST_STEP eighth-decibel steps per sample (0.5 dB by default), and the output is exactly zero no later than 256 samples after the write.
- R9: After fast mute, the output stays silent while only FFh is written. A later ordinary code clears fast mute, and the level then rises at the normal rate of R7.
- R10: outValid is asserted exactly one cycle after inValid. The gain level does not move on cycles without inValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Write strobe for ctrlWord |
| ctrlWord | input | 16 | Volume code [15:8], fine step [7:5], clipping mode [4:0] |
| inValid | input | 1 | Input sample pair valid |
| inLeft | input | SAMPLE_W | Left input sample, signed |
| inRight | input | SAMPLE_W | Right input sample, signed |
| outValid | output | 1 | Output sample pair valid |
| outLeft | output | SAMPLE_W | Left output sample, signed and saturated |
| outRight | output | SAMPLE_W | Right output sample, signed and saturated |

## Verification
The bench builds the block with SAMPLE_W = 16 and FAST_STEP = 4. With 16-bit samples, saturation is reached at +12 dB from inputs near 8200, and the bench drives both rails. A fast step of four eighths lets the full ramp from 0 dB finish after 229 samples, so the bench can observe the 256-sample silence bound. With these values the normal ramp, its pause on idle cycles and the slow climb out of fast mute each resolve within a few hundred samples. Each of those points is checked against a gain computed from the decibel law with a one-LSB tolerance.

// File: rtl/vol_pkg.sv
package vol_pkg;
  // level 0 is silence; level n (1..LVL_MAX) means (n - LVL_UNITY)/8 dB
  localparam int LVL_W = 10;
  localparam logic [LVL_W-1:0] LVL_UNITY = 10'd913;
  localparam int LVL_MAX = 1016;
  localparam int OCT_STEPS = 48;             // eighth-dB steps per 6 dB octave
  localparam int FRAC_IW = $clog2(OCT_STEPS);
  localparam logic [4:0] CLIP_LIMIT = 5'd0;  // clipping mode that caps gain at 0 dB
  localparam logic [7:0] FAST_CODE = 8'hFF;

  typedef struct packed {
    logic sampleEn;
    logic [LVL_W-1:0] level;
  } volStrobe_t;
endpackage

// File: rtl/vol_ctrl.sv
module vol_ctrl
  import vol_pkg::*;
#(
  parameter int FAST_STEP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [15:0] ctrlWord,
  input  logic        inValid,
  output volStrobe_t  strobe
);
  localparam logic [LVL_W-1:0] FAST_AMT = LVL_W'(FAST_STEP);

  logic [LVL_W-1:0] curLevel, tgtLevel, newTgt, stepAmt, nextLevel;
  logic fastMode;
  logic [7:0] code, codeSat;

  always_comb begin
    code = ctrlWord[15:8];
    codeSat = (code > 8'h7F) ? 8'h7F : code;
    if (codeSat == 8'h00) newTgt = '0;
    else newTgt = {codeSat[6:0] - 7'd1, ctrlWord[7:5]} + LVL_W'(1);
    if (ctrlWord[4:0] == CLIP_LIMIT && newTgt > LVL_UNITY) newTgt = LVL_UNITY;
  end

  always_comb begin
    stepAmt = fastMode ? FAST_AMT : LVL_W'(1);
    if (curLevel < tgtLevel)
      nextLevel = (tgtLevel - curLevel > stepAmt) ? curLevel + stepAmt : tgtLevel;
    else if (curLevel > tgtLevel)
      nextLevel = (curLevel - tgtLevel > stepAmt) ? curLevel - stepAmt : tgtLevel;
    else
      nextLevel = curLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= '0;
      tgtLevel <= '0;
      fastMode <= 1'b0;
    end else begin
      if (inValid) curLevel <= nextLevel;
      if (ctrlWe) begin
        if (code == FAST_CODE) begin
          fastMode <= 1'b1;
          tgtLevel <= '0;
        end else begin
          fastMode <= 1'b0;
          tgtLevel <= newTgt;
        end
      end
    end
  end

  assign strobe.sampleEn = inValid;
  assign strobe.level = curLevel;

  // R7 / R8: the level never jumps by more than the fast step
  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((curLevel > $past(curLevel)) ? (curLevel - $past(curLevel))
                                  : ($past(curLevel) - curLevel)) <= FAST_AMT);

  // R10: no accepted sample, no movement
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(curLevel));

  // R8: fast mute descends by the full fast step while far from silence
  assert_fast_rate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fastMode && !ctrlWe && curLevel >= FAST_AMT)
      |=> curLevel == $past(curLevel) - FAST_AMT);
endmodule

// File: rtl/vol_datapath.sv
module vol_datapath
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  volStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight
);
  localparam int MANT_W = 16;
  localparam int MANT_FB = MANT_W - 1;                       // mantissa 1.0 = 2^15
  localparam int PROD_W = SAMPLE_W + MANT_W + 1;
  localparam int MAX_OCT = (LVL_MAX - 1) / OCT_STEPS;
  localparam int UNITY_OCT = (int'(LVL_UNITY) - 1) / OCT_STEPS;
  localparam int RSH = MANT_FB + UNITY_OCT;
  localparam int SH_W = PROD_W + MAX_OCT;
  localparam logic signed [SH_W-1:0] HALF = {{(SH_W-RSH){1'b0}}, 1'b1, {(RSH-1){1'b0}}};
  localparam logic signed [SH_W-1:0] POS_LIM = SH_W'((2 ** (SAMPLE_W-1)) - 1);
  localparam logic signed [SH_W-1:0] NEG_LIM = -SH_W'(2 ** (SAMPLE_W-1));

  function automatic int mantOf(input int k);
    real r;
    r = (2.0 ** MANT_FB) * (2.0 ** (real'(k) / real'(OCT_STEPS)));
    return $rtoi(r + 0.5);
  endfunction

  logic [MANT_W-1:0] mantRom [OCT_STEPS];
  for (genvar k = 0; k < OCT_STEPS; k++) begin : g_rom
    localparam int M = mantOf(k);
    assign mantRom[k] = MANT_W'(M);
  end

  logic [LVL_W-1:0] levM1, oct;
  logic [FRAC_IW-1:0] frac;
  logic [MANT_W-1:0] mant;
  logic silent;

  assign silent = (strobe.level == '0);
  assign levM1 = strobe.level - LVL_W'(1);
  assign oct = levM1 / LVL_W'(OCT_STEPS);
  assign frac = FRAC_IW'(levM1 % LVL_W'(OCT_STEPS));
  assign mant = mantRom[frac];

  logic signed [SAMPLE_W-1:0] smpIn [2];
  logic signed [SAMPLE_W-1:0] smpOut [2];
  assign smpIn[0] = inLeft;
  assign smpIn[1] = inRight;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    logic signed [SH_W-1:0] wide, rounded;
    assign prod = smpIn[ch] * $signed({1'b0, mant});
    assign wide = SH_W'(prod) <<< oct;
    assign rounded = (wide + HALF) >>> RSH;
    always_ff @(posedge clk) begin
      if (!rstN) smpOut[ch] <= '0;
      else if (strobe.sampleEn) begin
        if (silent) smpOut[ch] <= '0;
        else if (rounded > POS_LIM) smpOut[ch] <= POS_LIM[SAMPLE_W-1:0];
        else if (rounded < NEG_LIM) smpOut[ch] <= NEG_LIM[SAMPLE_W-1:0];
        else smpOut[ch] <= rounded[SAMPLE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= strobe.sampleEn;
  end

  assign outLeft = smpOut[0];
  assign outRight = smpOut[1];

  // R3: a sample taken at the silent level comes out as exact zero
  assert_silent_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleEn && strobe.level == '0) |=> (outLeft == '0 && outRight == '0));

  // R10: output strobe follows the input strobe by one cycle
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleEn |=> outValid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleEn |=> !outValid);
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FAST_STEP = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlWe,
  input  logic [15:0]                ctrlWord,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight
);
  volStrobe_t strobe;

  vol_ctrl #(.FAST_STEP(FAST_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .inValid(inValid), .strobe(strobe)
  );

  vol_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inLeft(inLeft), .inRight(inRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight)
  );
endmodule

// File: tb/tb_vol_stepper.sv
`timescale 1ns/1ps
module tb_vol_stepper;
  logic clk = 1'b0;
  logic rstN, ctrlWe, inValid;
  logic [15:0] ctrlWord;
  logic signed [15:0] inLeft, inRight;
  logic outValid;
  logic signed [15:0] outLeft, outRight;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  vol_stepper #(.SAMPLE_W(16), .FAST_STEP(4)) dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .outValid(outValid), .outLeft(outLeft),
    .outRight(outRight)
  );

  function automatic int expOut(input int x, input real db);
    real e;
    int r;
    e = real'(x) * (2.0 ** (db / 6.0));
    r = (e >= 0.0) ? $rtoi(e + 0.5) : -$rtoi(-e + 0.5);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic chkEq(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chkNear(input string tag, input int got, input int exp);
    checks++;
    if (got > exp + 1 || got < exp - 1) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d (+-1)", tag, got, exp);
    end
  endtask

  task automatic writeCtrl(input logic [15:0] w);
    ctrlWe = 1'b1; ctrlWord = w;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic feed(input int l, input int r, output int ol, output int orr, output logic v);
    inValid = 1'b1; inLeft = 16'(l); inRight = 16'(r);
    @(negedge clk);
    ol = int'(outLeft); orr = int'(outRight); v = outValid;
    inValid = 1'b0;
  endtask

  task automatic settle();
    int a, b; logic v;
    for (int i = 0; i < 1100; i++) feed(0, 0, a, b, v);
  endtask

  task automatic tReset();
    int a, b; logic v;
    rstN = 1'b0; ctrlWe = 1'b0; ctrlWord = '0; inValid = 1'b0; inLeft = '0; inRight = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R10 reset outValid", int'(outValid), 0);
    chkEq("R3 reset outLeft", int'(outLeft), 0);
    feed(20000, -20000, a, b, v);
    chkEq("R3 reset mute left", a, 0);
    chkEq("R3 reset mute right", b, 0);
    chkEq("R10 outValid after sample", int'(v), 1);
  endtask

  task automatic tGainLaw();
    int a, b; logic v;
    writeCtrl(16'h7301); settle();
    feed(12345, -12345, a, b, v);
    chkNear("R1 unity left", a, 12345);
    chkNear("R1 unity right", b, -12345);
    writeCtrl(16'h7021); settle();
    feed(10000, 3000, a, b, v);
    chkNear("R1 -2.875dB", a, expOut(10000, -2.875));
    chkNear("R1 -2.875dB right", b, expOut(3000, -2.875));
    writeCtrl(16'h3701); settle();
    feed(32767, -32767, a, b, v);
    chkNear("R1 -60dB", a, expOut(32767, -60.0));
  endtask

  task automatic tExtremes();
    int a, b; logic v;
    writeCtrl(16'h7F01); settle();
    feed(5000, -5000, a, b, v);
    chkNear("R2 +12dB", a, expOut(5000, 12.0));
    chkNear("R2 +12dB right", b, expOut(-5000, 12.0));
    feed(10000, -10000, a, b, v);
    chkEq("R6 saturate high", a, 32767);
    chkEq("R6 saturate low", b, -32768);
    writeCtrl(16'h9001); settle();
    feed(2000, 0, a, b, v);
    chkNear("R2 code 90h acts as 7Fh", a, expOut(2000, 12.0));
    writeCtrl(16'h0101); settle();
    feed(32767, 32767, a, b, v);
    chkEq("R2 -114dB", a, expOut(32767, -114.0));
  endtask

  task automatic tFineClip();
    int a, b; logic v;
    writeCtrl(16'h73E1); settle();
    feed(10000, -10000, a, b, v);
    chkNear("R4 +0.875dB", a, expOut(10000, 0.875));
    writeCtrl(16'h7F00); settle();
    feed(5000, -7000, a, b, v);
    chkNear("R5 limit caps at 0dB left", a, 5000);
    chkNear("R5 limit caps at 0dB right", b, -7000);
    writeCtrl(16'h73E0); settle();
    feed(20000, 0, a, b, v);
    chkNear("R5 limit caps fine step", a, 20000);
  endtask

  task automatic tRamp();
    int a, b; logic v;
    writeCtrl(16'h7301); settle();
    writeCtrl(16'h7901);
    for (int k = 0; k < 24; k++) begin
      feed(8000, -8000, a, b, v);
      if (k == 0) chkNear("R7 first sample keeps old gain", a, 8000);
      if (k == 8) chkNear("R7 one dB after eight samples", a, expOut(8000, 1.0));
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 29) chkEq("R10 no outValid when idle", int'(outValid), 0);
    end
    for (int k = 24; k < 60; k++) begin
      feed(8000, -8000, a, b, v);
      if (k == 24) chkNear("R10 ramp paused while idle", a, expOut(8000, 3.0));
      if (k == 48) chkNear("R7 ramp reaches +6dB", a, 16000);
      if (k == 59) chkNear("R7 ramp holds at target", b, -16000);
    end
  endtask

  task automatic tFastMute();
    int a, b; logic v;
    writeCtrl(16'h7301); settle();
    writeCtrl(16'hFF00);
    for (int k = 0; k < 260; k++) begin
      feed(16000, -16000, a, b, v);
      if (k == 0) chkNear("R8 start level", a, 16000);
      if (k == 12) chkNear("R8 half dB per sample", a, 8000);
      if (k == 100) begin
        checks++;
        if (a <= 0) begin
          errs++;
          $display("FAIL R8 ramp not gradual: got %0d expected >0", a);
        end
      end
      if (k == 255) begin
        chkEq("R8 silent by 256 left", a, 0);
        chkEq("R8 silent by 256 right", b, 0);
      end
    end
  endtask

  task automatic tStayMuted();
    int a, b; logic v;
    writeCtrl(16'hFF00);
    for (int k = 0; k < 50; k++) feed(30000, 30000, a, b, v);
    chkEq("R9 still silent after FFh rewrite", a, 0);
    writeCtrl(16'h7301);
    for (int k = 0; k < 461; k++) begin
      feed(16000, 16000, a, b, v);
      if (k == 0) chkEq("R9 first sample still silent", a, 0);
      if (k == 460) chkNear("R9 normal-rate climb", a, expOut(16000, -56.625));
    end
    settle();
    feed(16000, -16000, a, b, v);
    chkNear("R9 back to unity", a, 16000);
  endtask

  initial begin
    tReset();
    tGainLaw();
    tExtremes();
    tFineClip();
    tRamp();
    tFastMute();
    tStayMuted();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule